// File: doc/BRIEF.md
# Exit-Point Profiling Counter Cache

This block counts how often each exit of a translated code group is taken, so that a monitor can spot the hot exits worth retranslating. Every time a group exit fires, the exit address is presented on the event port. The block finds the counter tagged with that address and adds one to it, with no software action needed. If no counter holds that address, the block claims an entry for it.

The counters live in a set-associative array. The default is 8 ways by 1024 sets, which gives 8192 counters. A monitor can read the count for any exit address through a separate read port, and can optionally zero it in the same request. A programmable threshold raises a one-cycle hot pulse, together with the exit address, at the moment a counter first reaches that value.

Top module: `exitprof_cache`

## Requirements
- R1: After reset no entry is resident. Every read misses with count 0, and neither hot_pulse nor rd_done is raised until a request arrives.
- R2: Bits [1:0] of an address are ignored. The set index is bits [IDX_W+1:2], where IDX_W = log2(SETS), and the tag is all bits above the index.
- R3: An exit event whose address is resident adds exactly one to that entry's counter.
- R4: An exit event whose address is not resident allocates an entry with count 1. Empty ways of the set are used before any resident entry is replaced.
- R5: When every way of the set is occupied, a missing event replaces the entry whose last exit event is oldest. Reads and clears do not change this recency order.
- R6: A counter that holds the maximum value 2^CNT_W-1 stays at that value on further events.
- R7: A read request is answered in the next cycle with rd_done=1, rd_hit and rd_count. A miss returns rd_hit=0 and count 0. When no answer is due, all three outputs are 0.
- R8: A read with rd_clear set zeroes the count of the matching entry only. The entry stays resident, and its next event brings it to 1. A clear that targets an entry evicted in that same cycle has no effect on the new occupant.
- R9: When an event and a read name the same entry in the same cycle, the read returns the count after the increment. If the read also clears, the stored count afterwards is 0.
- R10: hot_pulse is high for one cycle in the cycle after an event whose increment makes the count equal to threshold. An event on a saturated counter raises no pulse, and a threshold of 0 never raises one.
- R11: While hot_pulse is high, hot_addr holds the address of the event that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A group exit fired this cycle |
| ev_addr | input | ADDR_W | Exit-point address of the event |
| rd_valid | input | 1 | Monitor read request |
| rd_clear | input | 1 | Zero the matching counter as part of the read |
| rd_addr | input | ADDR_W | Exit address being queried |
| threshold | input | CNT_W | Count value that raises the hot pulse |
| rd_done | output | 1 | Read answer valid, one cycle after the request |
| rd_hit | output | 1 | Queried address was resident |
| rd_count | output | CNT_W | Count returned by the read |
| hot_pulse | output | 1 | A counter just reached threshold |
| hot_addr | output | ADDR_W | Address whose counter reached threshold |

## Verification
Two functions can act on one entry in a single cycle: the automatic increment from an exit event, and a monitor read or clear. The bench provokes this by driving both ports with the same word address, with different low bits, and with and without the clear. It also drives a clear aimed at the very entry that a simultaneous miss evicts. Each answer is judged against a per-entry model that applies the event first and then either returns the post-increment count or applies the clear to whatever entry still holds that tag.

// File: rtl/exitprof_pkg.sv
package exitprof_pkg;

    localparam int DEF_ADDR_W = 32;
    localparam int DEF_SETS   = 1024;
    localparam int DEF_WAYS   = 8;
    localparam int DEF_CNT_W  = 16;

    // What an exit event does to its set
    typedef enum logic [1:0] {
        EVK_NONE  = 2'd0,
        EVK_HIT   = 2'd1,
        EVK_FILL  = 2'd2,
        EVK_EVICT = 2'd3
    } ev_kind_e;

    // Saturating increment on a value of up to 32 bits
    function automatic logic [31:0] bump_sat(input logic [31:0] cur, input logic [31:0] lim);
        return (cur >= lim) ? cur : cur + 32'd1;
    endfunction

endpackage

// File: rtl/exitprof_way.sv
module exitprof_way #(
    parameter int SETS  = 1024,
    parameter int TAG_W = 20,
    parameter int CNT_W = 16,
    parameter int AGE_W = 3,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] ev_set,
    input  logic [IDX_W-1:0] rd_set,
    output logic             ev_vld,
    output logic [TAG_W-1:0] ev_tag,
    output logic [CNT_W-1:0] ev_cnt,
    output logic [AGE_W-1:0] ev_age,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [CNT_W-1:0] rd_cnt,
    input  logic             ent_we,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             age_we,
    input  logic [AGE_W-1:0] age_d,
    input  logic             clr_we,
    input  logic [IDX_W-1:0] clr_set
);

    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];
    logic [CNT_W-1:0] cnt_q [SETS];
    logic [AGE_W-1:0] age_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (ent_we) begin
            vld_q[ev_set] <= 1'b1;
        end
    end

    // Clear is written after the event update so that it wins on the same entry
    always_ff @(posedge clk) begin
        if (!rst) begin
            if (ent_we) begin
                tag_q[ev_set] <= wr_tag;
                cnt_q[ev_set] <= wr_cnt;
            end
            if (age_we) begin
                age_q[ev_set] <= age_d;
            end
            if (clr_we) begin
                cnt_q[clr_set] <= '0;
            end
        end
    end

    assign ev_vld = vld_q[ev_set];
    assign ev_tag = tag_q[ev_set];
    assign ev_cnt = cnt_q[ev_set];
    assign ev_age = age_q[ev_set];
    assign rd_vld = vld_q[rd_set];
    assign rd_tag = tag_q[rd_set];
    assign rd_cnt = cnt_q[rd_set];

endmodule

// File: rtl/exitprof_lru.sv
module exitprof_lru #(
    parameter int WAYS = 8,
    localparam int WAY_W = $clog2(WAYS),
    localparam int AGE_W = WAY_W
) (
    input  logic [WAYS-1:0]       vld,
    input  logic [WAYS*AGE_W-1:0] age,
    input  logic [WAYS-1:0]       hit_vec,
    output logic                  is_hit,
    output logic [WAY_W-1:0]      tgt_way,
    output logic                  tgt_vld,
    output logic [WAYS*AGE_W-1:0] age_next
);

    localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] free_way;
    logic             free_found;
    logic [WAY_W-1:0] old_way;
    logic [AGE_W-1:0] old_age;
    logic [AGE_W-1:0] ref_age;

    always_comb begin
        hit_way    = '0;
        free_way   = '0;
        free_found = 1'b0;
        old_way    = '0;
        old_age    = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
            end
            if (!vld[w] && !free_found) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
            if (age[w*AGE_W +: AGE_W] >= old_age) begin
                old_age = age[w*AGE_W +: AGE_W];
                old_way = WAY_W'(w);
            end
        end
        is_hit  = |hit_vec;
        tgt_way = is_hit ? hit_way : (free_found ? free_way : old_way);
        tgt_vld = vld[tgt_way];
        // An empty way enters as if it were the oldest
        ref_age = (is_hit || tgt_vld) ? age[tgt_way*AGE_W +: AGE_W] : AGE_OLDEST;
        for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == tgt_way) begin
                age_next[w*AGE_W +: AGE_W] = '0;
            end else if (age[w*AGE_W +: AGE_W] < ref_age) begin
                age_next[w*AGE_W +: AGE_W] = age[w*AGE_W +: AGE_W] + AGE_W'(1);
            end else begin
                age_next[w*AGE_W +: AGE_W] = age[w*AGE_W +: AGE_W];
            end
        end
    end

endmodule

// File: rtl/exitprof_cache.sv
module exitprof_cache
    import exitprof_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int SETS   = DEF_SETS,
    parameter int WAYS   = DEF_WAYS,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              rd_valid,
    input  logic              rd_clear,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  threshold,
    output logic              rd_done,
    output logic              rd_hit,
    output logic [CNT_W-1:0]  rd_count,
    output logic              hot_pulse,
    output logic [ADDR_W-1:0] hot_addr
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - 2;
    localparam int WAY_W = $clog2(WAYS);
    localparam int AGE_W = WAY_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] set;
    } loc_t;

    typedef struct packed {
        logic             hit;
        logic [CNT_W-1:0] cnt;
    } rd_res_t;

    function automatic loc_t split_addr(input logic [ADDR_W-1:0] a);
        loc_t l;
        l.set = a[IDX_W+1:2];
        l.tag = a[ADDR_W-1:IDX_W+2];
        return l;
    endfunction

    loc_t ev_loc, rd_loc;
    assign ev_loc = split_addr(ev_addr);
    assign rd_loc = split_addr(rd_addr);

    logic             w_ev_vld [WAYS];
    logic [TAG_W-1:0] w_ev_tag [WAYS];
    logic [CNT_W-1:0] w_ev_cnt [WAYS];
    logic [AGE_W-1:0] w_ev_age [WAYS];
    logic             w_rd_vld [WAYS];
    logic [TAG_W-1:0] w_rd_tag [WAYS];
    logic [CNT_W-1:0] w_rd_cnt [WAYS];

    logic [WAYS-1:0]       vld_vec;
    logic [WAYS*AGE_W-1:0] age_flat;
    logic [WAYS*AGE_W-1:0] age_next;
    logic [WAYS-1:0]       hit_vec;
    logic [WAYS-1:0]       rhit_vec;

    logic             is_hit;
    logic [WAY_W-1:0] tgt_way;
    logic             tgt_vld;
    ev_kind_e         ev_kind;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] new_cnt;
    logic             inc_made;

    logic             rd_any;
    logic [WAY_W-1:0] rd_way;
    logic [CNT_W-1:0] rd_cnt_sel;
    logic             rd_same;
    logic             clr_now;
    logic [WAY_W-1:0] clr_way;
    logic [IDX_W-1:0] clr_set;
    rd_res_t          rd_res;

    logic              rd_done_q;
    rd_res_t           rd_res_q;
    logic              hot_q;
    logic [ADDR_W-1:0] hot_addr_q;

    // Tag compare on both lookup paths
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            vld_vec[w]  = w_ev_vld[w];
            hit_vec[w]  = w_ev_vld[w] && (w_ev_tag[w] == ev_loc.tag);
            rhit_vec[w] = w_rd_vld[w] && (w_rd_tag[w] == rd_loc.tag);
        end
    end

    exitprof_lru #(.WAYS(WAYS)) u_lru (
        .vld      (vld_vec),
        .age      (age_flat),
        .hit_vec  (hit_vec),
        .is_hit   (is_hit),
        .tgt_way  (tgt_way),
        .tgt_vld  (tgt_vld),
        .age_next (age_next)
    );

    // Event path
    always_comb begin
        cur_cnt = w_ev_cnt[tgt_way];
        if (!ev_valid)    ev_kind = EVK_NONE;
        else if (is_hit)  ev_kind = EVK_HIT;
        else if (tgt_vld) ev_kind = EVK_EVICT;
        else              ev_kind = EVK_FILL;
        new_cnt  = (ev_kind == EVK_HIT) ? CNT_W'(bump_sat(32'(cur_cnt), 32'(CNT_MAX)))
                                        : CNT_W'(1);
        inc_made = (ev_kind != EVK_NONE) && ((ev_kind != EVK_HIT) || (cur_cnt != CNT_MAX));
    end

    // Read path
    always_comb begin
        rd_way     = '0;
        rd_cnt_sel = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (rhit_vec[w]) begin
                rd_way     = WAY_W'(w);
                rd_cnt_sel = w_rd_cnt[w];
            end
        end
        rd_any  = |rhit_vec;
        rd_same = ev_valid && ((rd_addr >> 2) == (ev_addr >> 2));
        if (rd_same) begin
            rd_res.hit = 1'b1;
            rd_res.cnt = new_cnt;
        end else begin
            rd_res.hit = rd_any;
            rd_res.cnt = rd_cnt_sel;
        end
        clr_way = rd_same ? tgt_way : rd_way;
        clr_set = rd_loc.set;
        // A clear aimed at the way being evicted this cycle is dropped
        clr_now = rd_valid && rd_clear &&
                  (rd_same || (rd_any && !((ev_kind == EVK_EVICT) &&
                                           (ev_loc.set == rd_loc.set) &&
                                           (tgt_way == rd_way))));
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign age_flat[g*AGE_W +: AGE_W] = w_ev_age[g];

        exitprof_way #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .CNT_W (CNT_W),
            .AGE_W (AGE_W)
        ) u_way (
            .clk     (clk),
            .rst     (rst),
            .ev_set  (ev_loc.set),
            .rd_set  (rd_loc.set),
            .ev_vld  (w_ev_vld[g]),
            .ev_tag  (w_ev_tag[g]),
            .ev_cnt  (w_ev_cnt[g]),
            .ev_age  (w_ev_age[g]),
            .rd_vld  (w_rd_vld[g]),
            .rd_tag  (w_rd_tag[g]),
            .rd_cnt  (w_rd_cnt[g]),
            .ent_we  ((ev_kind != EVK_NONE) && (tgt_way == WAY_W'(g))),
            .wr_tag  (ev_loc.tag),
            .wr_cnt  (new_cnt),
            .age_we  (ev_kind != EVK_NONE),
            .age_d   (age_next[g*AGE_W +: AGE_W]),
            .clr_we  (clr_now && (clr_way == WAY_W'(g))),
            .clr_set (clr_set)
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_done_q  <= 1'b0;
            rd_res_q   <= '0;
            hot_q      <= 1'b0;
            hot_addr_q <= '0;
        end else begin
            rd_done_q  <= rd_valid;
            rd_res_q   <= rd_valid ? rd_res : '0;
            hot_q      <= inc_made && (new_cnt == threshold);
            hot_addr_q <= ev_addr;
        end
    end

    assign rd_done   = rd_done_q;
    assign rd_hit    = rd_res_q.hit;
    assign rd_count  = rd_res_q.cnt;
    assign hot_pulse = hot_q;
    assign hot_addr  = hot_addr_q;

endmodule

// File: rtl/exitprof_checker.sv
module exitprof_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ev_valid,
    input logic [ADDR_W-1:0] ev_addr,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  threshold,
    input logic              rd_done,
    input logic              rd_hit,
    input logic [CNT_W-1:0]  rd_count,
    input logic              hot_pulse,
    input logic [ADDR_W-1:0] hot_addr
);

    // R1: first cycle out of reset is quiet
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rd_done && !hot_pulse));

    // R7: answer follows request by one cycle
    p_read_latency_r7: assert property (@(posedge clk) disable iff (rst)
        rd_done == $past(rd_valid));

    // R7: nothing reported without an answer, and a miss carries no count
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_done || !rd_hit) |-> (rd_count == '0 && (rd_done || !rd_hit)));

    // R9: same-entry event and read always hit with a counted value
    p_same_entry_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rd_valid && ev_valid && ((rd_addr >> 2) == (ev_addr >> 2)))
        |-> (rd_hit && rd_count != '0));

    // R10: a pulse needs a nonzero threshold and an event in the previous cycle
    p_hot_cause_r10: assert property (@(posedge clk) disable iff (rst)
        hot_pulse |-> ($past(ev_valid) && $past(threshold) != '0));

    // R11: pulse carries the causing address
    p_hot_addr_r11: assert property (@(posedge clk) disable iff (rst)
        hot_pulse |-> (hot_addr == $past(ev_addr)));

endmodule

bind exitprof_cache exitprof_checker #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
) u_exitprof_checker (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (ev_valid),
    .ev_addr   (ev_addr),
    .rd_valid  (rd_valid),
    .rd_addr   (rd_addr),
    .threshold (threshold),
    .rd_done   (rd_done),
    .rd_hit    (rd_hit),
    .rd_count  (rd_count),
    .hot_pulse (hot_pulse),
    .hot_addr  (hot_addr)
);

// File: tb/exitprof_cache_bench.sv
module exitprof_cache_bench;

    localparam int AW   = 12;
    localparam int NS   = 4;
    localparam int NW   = 4;
    localparam int CW   = 4;
    localparam int CMAX = 15;
    localparam time TCK = 8ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ev_valid = 1'b0;
    logic [AW-1:0] ev_addr = '0;
    logic          rd_valid = 1'b0;
    logic          rd_clear = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] threshold = '0;
    logic          rd_done, rd_hit, hot_pulse;
    logic [CW-1:0] rd_count;
    logic [AW-1:0] hot_addr;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    exitprof_cache #(.ADDR_W(AW), .SETS(NS), .WAYS(NW), .CNT_W(CW)) u_exitprof_cache (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_addr(ev_addr),
        .rd_valid(rd_valid), .rd_clear(rd_clear), .rd_addr(rd_addr),
        .threshold(threshold), .rd_done(rd_done), .rd_hit(rd_hit),
        .rd_count(rd_count), .hot_pulse(hot_pulse), .hot_addr(hot_addr)
    );

    // Reference model, recency by time stamps
    bit m_v [NS][NW];
    int m_t [NS][NW];
    int m_c [NS][NW];
    int m_s [NS][NW];
    int now = 0;

    function automatic int mk(int tag, int set, int low);
        return (tag << 4) | (set << 2) | low;
    endfunction

    function automatic int find(int s, int t);
        for (int w = 0; w < NW; w++) if (m_v[s][w] && m_t[s][w] == t) return w;
        return -1;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    task automatic step(bit ev, int ea, bit rv, bit rc, int ra, int thr, string req);
        int rs, rt, rw, es, et, w, old, nc, exp_cnt;
        bit exp_hit, exp_hot, same;
        ev_valid = ev; ev_addr = AW'(ea);
        rd_valid = rv; rd_clear = rc; rd_addr = AW'(ra);
        threshold = CW'(thr);
        rs = (ra >> 2) & 3; rt = ra >> 4; rw = find(rs, rt);
        exp_hit = (rw >= 0);
        exp_cnt = (rw >= 0) ? m_c[rs][rw] : 0;
        exp_hot = 0;
        same = ev && rv && ((ea >> 2) == (ra >> 2));
        if (ev) begin
            es = (ea >> 2) & 3; et = ea >> 4; w = find(es, et);
            now++;
            if (w >= 0) begin
                old = m_c[es][w];
                nc = (old == CMAX) ? old : old + 1;
                exp_hot = (nc != old) && (nc == thr);
                m_c[es][w] = nc; m_s[es][w] = now;
            end else begin
                w = -1;
                for (int k = 0; k < NW; k++) if (!m_v[es][k] && w < 0) w = k;
                if (w < 0) begin
                    w = 0;
                    for (int k = 1; k < NW; k++) if (m_s[es][k] < m_s[es][w]) w = k;
                end
                m_v[es][w] = 1; m_t[es][w] = et; m_c[es][w] = 1; m_s[es][w] = now;
                exp_hot = (thr == 1);
            end
        end
        if (same) begin
            w = find(rs, rt);
            exp_hit = 1; exp_cnt = m_c[rs][w];
            if (rc) m_c[rs][w] = 0;
        end else if (rv && rc && rw >= 0) begin
            if (m_v[rs][rw] && m_t[rs][rw] == rt) m_c[rs][rw] = 0;
        end
        @(posedge clk); #2;
        chk(rd_done == rv, req, "rd_done", int'(rd_done), int'(rv));
        if (rv) begin
            chk(rd_hit == exp_hit, req, "rd_hit", int'(rd_hit), int'(exp_hit));
            chk(int'(rd_count) == exp_cnt, req, "rd_count", int'(rd_count), exp_cnt);
        end
        chk(hot_pulse == exp_hot, req, "hot_pulse", int'(hot_pulse), int'(exp_hot));
        if (exp_hot) chk(int'(hot_addr) == ea, req, "hot_addr", int'(hot_addr), ea);
        ev_valid = 0; rd_valid = 0; rd_clear = 0;
    endtask

    task automatic rd(int a, string req);
        step(0, 0, 1, 0, a, 0, req);
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned x;
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        // R1: empty after reset
        @(posedge clk); #2;
        chk(rd_done == 0 && hot_pulse == 0, "R1", "idle outputs", int'(rd_done), 0);
        for (int s = 0; s < NS; s++) rd(mk(1, s, 0), "R1");

        // R4: fill every way of every set, threshold 0 never pulses (R10)
        for (int s = 0; s < NS; s++)
            for (int t = 1; t <= NW; t++) step(1, mk(t, s, 0), 0, 0, 0, 0, "R10");
        for (int s = 0; s < NS; s++)
            for (int t = 1; t <= NW; t++) rd(mk(t, s, 2), "R4");

        // R2: low bits ignored, neighbouring sets untouched
        step(1, mk(1, 0, 3), 0, 0, 0, 0, "R2");
        rd(mk(1, 0, 1), "R2");
        rd(mk(1, 1, 0), "R2");

        // R3: repeated hits
        for (int i = 0; i < 4; i++) begin
            step(1, mk(2, 3, 0), 0, 0, 0, 0, "R3");
            rd(mk(2, 3, 0), "R3");
        end

        // R5: recency by events only
        for (int t = 1; t <= NW; t++) step(1, mk(t, 2, 0), 0, 0, 0, 0, "R5");
        rd(mk(1, 2, 0), "R5");
        step(1, mk(9, 2, 0), 0, 0, 0, 0, "R5");
        rd(mk(1, 2, 0), "R5");
        rd(mk(2, 2, 0), "R5");
        rd(mk(9, 2, 0), "R5");

        // R6 and R10: saturate with a threshold of 5
        for (int i = 0; i < 20; i++) begin
            step(1, mk(3, 1, 0), 0, 0, 0, 5, "R6");
        end
        rd(mk(3, 1, 0), "R6");

        // R8: clear only the matching entry, it stays resident
        step(0, 0, 1, 1, mk(2, 2, 0), 0, "R8");
        rd(mk(2, 2, 0), "R8");
        rd(mk(3, 2, 0), "R8");
        step(1, mk(2, 2, 0), 0, 0, 0, 0, "R8");
        rd(mk(2, 2, 0), "R8");

        // R8: clear aimed at an entry evicted in the same cycle
        step(0, 0, 1, 1, mk(3, 2, 0), 0, "R8");
        step(1, mk(12, 2, 0), 1, 1, mk(3, 2, 0), 0, "R8");
        rd(mk(12, 2, 0), "R8");

        // R9: same entry in the same cycle, with and without clear
        step(1, mk(4, 3, 1), 1, 0, mk(4, 3, 2), 0, "R9");
        step(1, mk(4, 3, 0), 1, 1, mk(4, 3, 0), 0, "R9");
        rd(mk(4, 3, 0), "R9");
        step(1, mk(14, 0, 0), 1, 0, mk(14, 0, 3), 0, "R9");

        // R11: pulse on allocation with threshold 1
        step(1, mk(15, 1, 2), 0, 0, 0, 1, "R11");

        // Pseudo-random mix against the model
        x = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            int ea, ra, th;
            bit ev, rv, rc;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            ev = x[0] | x[1];
            rv = x[2];
            rc = x[3] & x[4] & x[5];
            ea = mk(int'(x[10:8]) % 6, int'(x[12:11]), int'(x[14:13]));
            ra = x[15] ? ea : mk(int'(x[18:16]) % 6, int'(x[20:19]), int'(x[22:21]));
            th = int'(x[26:23]) % 8;
            step(ev, ea, rv, rc, ra, th, "R3");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule